// File: doc/BRIEF.md
# Flash Status Word with Sticky Errors

This block assembles the eight-bit status word that a flash controller reports to its host. It follows the program/erase engine through a small amount of state. It records whether an operation is running, whether a suspend was requested and then acknowledged, and which kind of operation is under way. It keeps four error flags that stay set until the host clears them explicitly. Starting a new program or erase does not clear them. The command sequencer and the program/erase model send single-cycle event pulses into the block.

The host never sees the live word directly. A snapshot is taken when either the chip-enable strobe or the output-enable strobe falls, both active low. The pins then hold that snapshot for as long as the strobes stay low. To see a later state, the host must toggle a strobe.

Top module: `flash_status_word`

## Requirements
- R1: Bit 7 reads 0 while an accepted operation is running and 1 when the engine is idle. An operation starts only when `op_start` arrives with `supply_ok` high while idle. It ends on `op_done`.
- R2: After `suspend_req`, bit 7 stays 0 until the engine acknowledges with `paused`. From that cycle bit 7 reads 1.
- R3: While a suspended operation is an erase, bit 6 is 1. While it is a program, bit 2 is 1. Both return to 0 on `resume`, and bit 7 then reads 0 again.
- R4: Error sources are as follows. A completion with `op_fail` sets bit 5 for an erase and bit 4 for a program. `op_start` with `supply_ok` low sets bit 3 and starts nothing. `locked_hit` sets bit 1.
- R5: Bits 5, 4, 3 and 1 stay set across later operations. Only `clear_req` or reset clears them.
- R6: Bit 0 always reads 0.
- R7: `status_out` takes the live word only in the cycle after a falling `ce_n` or `oe_n` is seen. It holds its value while both strobes stay steady.
- R8: `supply_ok` is looked at only when an operation starts. A low level while an operation runs, or while idle, leaves bit 3 unchanged.
- R9: If an error event and `clear_req` occur in the same cycle, the error bit ends up set.
- R10: After reset, `status_out` reads 0x80 (ready, no flags).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Pulse: host launched a program or erase |
| op_is_erase | input | 1 | Operation kind with `op_start` (1 = erase) |
| supply_ok | input | 1 | Program supply above lockout level |
| op_done | input | 1 | Pulse: engine finished the running operation |
| op_fail | input | 1 | Qualifies `op_done` as a failure |
| locked_hit | input | 1 | Pulse: modify attempt on a protected block |
| suspend_req | input | 1 | Pulse: host requested suspend |
| paused | input | 1 | Pulse: engine has actually paused |
| resume | input | 1 | Pulse: host resumed the suspended operation |
| clear_req | input | 1 | Pulse: clear the sticky error flags |
| ce_n | input | 1 | Chip-enable strobe, active low |
| oe_n | input | 1 | Output-enable strobe, active low |
| status_out | output | 8 | Captured status word |

## Verification
One walked sequence drives a program and then an erase through suspend, resume and failing completion. It reads the word after every step. This separates the two suspend bits, separates the two failure bits, and shows bit 7 staying low between request and acknowledge. The same sequence includes a start with the supply low, a clear that coincides with a lock hit, and a supply drop while busy. These steps tell a start-time sample apart from a live one and show which of event and clear wins. Directed cases hold `oe_n` low across a state change to show the frozen output, then capture through `ce_n`. A final case asserts reset over set flags.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int W = 8;
  localparam int B_READY = 7;
  localparam int B_ESUS  = 6;
  localparam int B_EFAIL = 5;
  localparam int B_PFAIL = 4;
  localparam int B_VLOW  = 3;
  localparam int B_PSUS  = 2;
  localparam int B_LOCK  = 1;
  localparam int NERR    = 4;
  localparam int E_LOCK  = 0;
  localparam int E_VLOW  = 1;
  localparam int E_PROG  = 2;
  localparam int E_ERASE = 3;
  localparam logic [W-1:0] RESET_WORD = 8'h80;

  function automatic logic [W-1:0] fsw_pack(input logic ready, input logic esus,
                                            input logic psus, input logic [NERR-1:0] err);
    logic [W-1:0] w;
    w = '0;
    w[B_READY] = ready;
    w[B_ESUS]  = esus;
    w[B_PSUS]  = psus;
    w[B_EFAIL] = err[E_ERASE];
    w[B_PFAIL] = err[E_PROG];
    w[B_VLOW]  = err[E_VLOW];
    w[B_LOCK]  = err[E_LOCK];
    return w;
  endfunction

  function automatic logic fsw_fall(input logic prev, input logic now);
    return prev & ~now;
  endfunction
endpackage

// File: rtl/fsw_engine_track.sv
module fsw_engine_track
  import fsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_start_i,
  input  logic op_is_erase_i,
  input  logic supply_ok_i,
  input  logic op_done_i,
  input  logic suspend_req_i,
  input  logic paused_i,
  input  logic resume_i,
  output logic start_ok_o,
  output logic start_low_o,
  output logic done_ok_o,
  output logic kind_erase_o,
  output logic ready_o,
  output logic esus_o,
  output logic psus_o
);
  logic busy_q, kind_q, pend_q, susp_q;
  logic start_ok, start_low, done_ok, pause_ack, resume_ok, req_ok;

  assign start_ok  = op_start_i & supply_ok_i & ~busy_q;
  assign start_low = op_start_i & ~supply_ok_i & ~busy_q;
  assign done_ok   = op_done_i & busy_q & ~susp_q;
  assign req_ok    = suspend_req_i & busy_q & ~susp_q;
  assign pause_ack = paused_i & pend_q & ~done_ok;
  assign resume_ok = resume_i & susp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      kind_q <= 1'b0;
      pend_q <= 1'b0;
      susp_q <= 1'b0;
    end else begin
      if (start_ok) begin
        busy_q <= 1'b1;
        kind_q <= op_is_erase_i;
      end else if (done_ok) begin
        busy_q <= 1'b0;
      end
      if (start_ok || done_ok || pause_ack) pend_q <= 1'b0;
      else if (req_ok) pend_q <= 1'b1;
      if (pause_ack) susp_q <= 1'b1;
      else if (resume_ok) susp_q <= 1'b0;
    end
  end

  assign start_ok_o   = start_ok;
  assign start_low_o  = start_low;
  assign done_ok_o    = done_ok;
  assign kind_erase_o = kind_q;
  assign ready_o      = ~busy_q | susp_q;
  assign esus_o       = susp_q & kind_q;
  assign psus_o       = susp_q & ~kind_q;

  // R2: the suspended state is entered only on an engine acknowledge
  assert_pause_needs_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> $past(paused_i));
  // R3: never both suspend indicators
  assert_one_suspend_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({esus_o, psus_o}));
  // R1: busy begins only from a start with good supply
  assert_busy_from_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(op_start_i && supply_ok_i));
endmodule

// File: rtl/fsw_error_flags.sv
module fsw_error_flags
  import fsw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done_ok_i,
  input  logic            fail_i,
  input  logic            kind_erase_i,
  input  logic            start_low_i,
  input  logic            locked_hit_i,
  input  logic            clear_i,
  output logic [NERR-1:0] err_o
);
  logic [NERR-1:0] err_q, evt, keep;

  always_comb begin
    evt = '0;
    evt[E_ERASE] = done_ok_i & fail_i & kind_erase_i;
    evt[E_PROG]  = done_ok_i & fail_i & ~kind_erase_i;
    evt[E_VLOW]  = start_low_i;
    evt[E_LOCK]  = locked_hit_i;
    keep = clear_i ? '0 : err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= keep | evt;
  end

  assign err_o = err_q;

  // R5: without a clear, no flag drops
  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> ((err_q & $past(err_q)) == $past(err_q)));
  // R9: lock event beats a simultaneous clear
  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && locked_hit_i) |=> err_q[E_LOCK]);
endmodule

// File: rtl/fsw_capture.sv
module fsw_capture
  import fsw_pkg::*;
#(
  parameter logic [W-1:0] INIT = RESET_WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce_n_i,
  input  logic         oe_n_i,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] snap_o
);
  logic ce_q, oe_q, fall_ce, fall_oe;
  logic [W-1:0] snap_q;

  assign fall_ce = fsw_fall(ce_q, ce_n_i);
  assign fall_oe = fsw_fall(oe_q, oe_n_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      snap_q <= INIT;
    end else begin
      ce_q <= ce_n_i;
      oe_q <= oe_n_i;
      if (fall_ce || fall_oe) snap_q <= live_i;
    end
  end

  assign snap_o = snap_q;

  // R7: output changes only after a strobe fall
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ce || fall_oe) |=> $stable(snap_q));
  // R6: reserved bit stays low at the pins
  assert_bit0_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snap_q[0] == 1'b0);
endmodule

// File: rtl/flash_status_word.sv
module flash_status_word
  import fsw_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_start,
  input  logic         op_is_erase,
  input  logic         supply_ok,
  input  logic         op_done,
  input  logic         op_fail,
  input  logic         locked_hit,
  input  logic         suspend_req,
  input  logic         paused,
  input  logic         resume,
  input  logic         clear_req,
  input  logic         ce_n,
  input  logic         oe_n,
  output logic [7:0]   status_out
);
  logic start_ok, start_low, done_ok, kind_erase, ready, esus, psus;
  logic [NERR-1:0] err;
  logic [W-1:0] live;

  fsw_engine_track u_track (
    .clk(clk), .rst_n(rst_n),
    .op_start_i(op_start), .op_is_erase_i(op_is_erase), .supply_ok_i(supply_ok),
    .op_done_i(op_done), .suspend_req_i(suspend_req), .paused_i(paused),
    .resume_i(resume),
    .start_ok_o(start_ok), .start_low_o(start_low), .done_ok_o(done_ok),
    .kind_erase_o(kind_erase), .ready_o(ready), .esus_o(esus), .psus_o(psus)
  );

  fsw_error_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .done_ok_i(done_ok), .fail_i(op_fail), .kind_erase_i(kind_erase),
    .start_low_i(start_low), .locked_hit_i(locked_hit), .clear_i(clear_req),
    .err_o(err)
  );

  assign live = fsw_pack(ready, esus, psus, err);

  fsw_capture #(.INIT(RESET_WORD)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .live_i(live), .snap_o(status_out)
  );

  // R8: a supply drop during a running operation does not raise the low-supply flag
  assert_supply_only_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !supply_ok && !err[E_VLOW]) |=> !err[E_VLOW]);

  logic unused_ok;
  assign unused_ok = start_ok;
endmodule

// File: tb/flash_status_word_tb.sv
module flash_status_word_tb;
  localparam int PERIOD = 10;
  localparam int NV = 18;
  // control [17:8]: start, erase, supply_ok, done, fail, locked, susp_req, paused, resume, clear
  localparam logic [17:0] VEC [NV] = '{
    {10'b0010000000, 8'h80},
    {10'b1010000000, 8'h00},
    {10'b0010001000, 8'h00},
    {10'b0010000100, 8'h84},
    {10'b0010000010, 8'h00},
    {10'b0011100000, 8'h90},
    {10'b1110000000, 8'h10},
    {10'b0010001000, 8'h10},
    {10'b0010000100, 8'hD0},
    {10'b0010000010, 8'h10},
    {10'b0011100000, 8'hB0},
    {10'b0010010000, 8'hB2},
    {10'b0010000001, 8'h80},
    {10'b1000000000, 8'h88},
    {10'b0010010001, 8'h82},
    {10'b1110000000, 8'h02},
    {10'b0000000000, 8'h02},
    {10'b0011000000, 8'h82}
  };

  logic clk = 0, rst_n = 0;
  logic op_start = 0, op_is_erase = 0, supply_ok = 1, op_done = 0, op_fail = 0;
  logic locked_hit = 0, suspend_req = 0, paused = 0, resume = 0, clear_req = 0;
  logic ce_n = 1, oe_n = 1;
  logic [7:0] status_out;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  flash_status_word u_dut (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_is_erase(op_is_erase),
    .supply_ok(supply_ok), .op_done(op_done), .op_fail(op_fail),
    .locked_hit(locked_hit), .suspend_req(suspend_req), .paused(paused),
    .resume(resume), .clear_req(clear_req), .ce_n(ce_n), .oe_n(oe_n),
    .status_out(status_out)
  );

  function automatic string vtag(input int i);
    case (i)
      0: return "R10 idle";
      1: return "R1 busy";
      2, 7: return "R2 request only";
      3, 8: return "R3 suspended";
      4, 9: return "R3 resumed";
      5, 10: return "R4 fail flag";
      6: return "R5 sticky over new op";
      11: return "R4 lock flag";
      12: return "R5 clear";
      13: return "R4 low supply";
      14: return "R9 event wins";
      15: return "R1 erase busy";
      16: return "R8 late supply drop";
      default: return "R1 done";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    op_start = 0; op_is_erase = 0; supply_ok = 1; op_done = 0; op_fail = 0;
    locked_hit = 0; suspend_req = 0; paused = 0; resume = 0; clear_req = 0;
  endtask

  // drop oe_n at a negedge, capture at the next posedge, sample at the following negedge
  task automatic read_word(output logic [7:0] w);
    oe_n = 0;
    @(negedge clk);
    w = status_out;
    oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] w;
    repeat (3) @(negedge clk);
    check("R10 reset pins", status_out, 8'h80);
    rst_n = 1;
    @(negedge clk);
    read_word(w);
    check("R10 reset read", w, 8'h80);

    for (int i = 0; i < NV; i++) begin
      {op_start, op_is_erase, supply_ok, op_done, op_fail, locked_hit,
       suspend_req, paused, resume, clear_req} = VEC[i][17:8];
      @(negedge clk);
      idle_inputs();
      read_word(w);
      check(vtag(i), w, VEC[i][7:0]);
      checks++;
      if (w[0] !== 1'b0) begin
        failures++;
        $display("FAIL R6 bit0 actual=%0b expected=0", w[0]);
      end
    end

    // R7: hold oe_n low across a state change; output must not follow
    oe_n = 0;
    @(negedge clk);
    check("R7 captured", status_out, 8'h82);
    op_start = 1;
    @(negedge clk);
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R7 frozen while held", status_out, 8'h82);
    oe_n = 1;
    @(negedge clk);
    check("R7 no capture on rise", status_out, 8'h82);
    ce_n = 0;
    @(negedge clk);
    check("R7 ce_n fall capture", status_out, 8'h02);
    ce_n = 1;
    op_done = 1;
    @(negedge clk);
    idle_inputs();
    read_word(w);
    check("R1 ready after done", w, 8'h82);

    // R5: reset clears sticky flags
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_word(w);
    check("R5 reset clears flags", w, 8'h80);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule